// File: doc/BRIEF.md
# Doorbell receive queue

This block takes incoming doorbell events, each carrying a 16-bit target ID, a 16-bit source ID and a 16-bit info word. It stores each one as an 8-byte record in a circular region of system memory and moves an enqueue pointer forward. A queued-item interrupt stays pending while records are waiting. Software reads the record at the dequeue pointer and then writes a command bit in the mode register, which moves the dequeue pointer past that record.

Events arrive on a valid/ready input. Records leave on a single-beat memory write port of 64 bits in big-endian byte order. Software uses a small word-addressed register port to set up the pointers, enable the unit, acknowledge status and advance the dequeue pointer. The region holds 512 record slots, which is 4 KB. Both pointers wrap inside the 4 KB window and keep their upper address bits.

Top module: `dbell_rx_queue`

## Requirements
- R1: After reset, the mode, status, dequeue pointer and enqueue pointer registers all read 0, and both `ev_ready` and `irq` are low.
- R2: In the cycle of an accepted event with `ev_err` low, `mem_wr_en` is high and `mem_wr_data` is {16'h0000, target, source, info}. This places the target at byte offset 2, the source at offset 4 and the info word at offset 6, most significant byte first.
- R3: The write address is the current enqueue pointer. After each record the enqueue pointer moves up by 8. Its low 12 bits wrap from 0xFF8 to 0x000 and the bits above them do not change.
- R4: A register write to the mode register (address 0) with bit 1 set moves the dequeue pointer forward by 8, with the same wrap rule as R3. This only happens if the queue is not empty. When the queue is empty the command is ignored.
- R5: The queue is empty when the dequeue pointer equals the enqueue pointer. Status bit 0 (queued) becomes 1 one cycle after the queue is non-empty. Writing 1 to it clears it for one cycle, and it sets again if records remain. `irq` equals queued AND enable.
- R6: The queue is full when the enqueue pointer plus 8 (wrapped) equals the dequeue pointer, so at most 511 records are pending. While full, `ev_ready` is low, no record is written, and an offered event sets status bit 4 (full).
- R7: An accepted event with `ev_err` high writes no record and leaves the enqueue pointer unchanged. It sets status bit 7 (reception error).
- R8: Status bits 7, 4 and 0 are write-one-to-clear at address 1. A write of 0x91 clears all three.
- R9: Mode bit 0 enables the unit and reads back. Bit 1 reads as 0. While the unit is disabled, `ev_ready` is low and no event is taken.
- R10: The dequeue pointer (address 2) and the enqueue pointer (address 3) are loaded by register writes and read back on `reg_rdata` in the same cycle that `reg_addr` selects them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Doorbell event offered |
| ev_ready | output | 1 | Event can be taken this cycle |
| ev_err | input | 1 | Event was received with an error |
| ev_tid | input | 16 | Target ID of the event |
| ev_sid | input | 16 | Source ID of the event |
| ev_info | input | 16 | Info word of the event |
| mem_wr_en | output | 1 | Record write strobe |
| mem_wr_addr | output | 32 | Byte address of the record |
| mem_wr_data | output | 64 | Record contents, big-endian |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mode, 1 status, 2 dequeue, 3 enqueue |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Queued-item interrupt |

## Verification
The bench starts the pointers just below the 4 KB boundary. A design that carried the wrap into the upper address bits, or that did not wrap at all, would write the third record outside the region. It then holds events valid until the queue fills. A design that treated equal pointers as full, or that let the 512th event in, would show a wrong accepted count or would overwrite the record at the dequeue pointer. Further cases cover an advance command on an empty queue, which a careless design would let run past the enqueue pointer. They also cover clearing the queued bit while records remain, where a design might lose the interrupt or never drop it. Finally, they send error events, which must not produce a record.

// File: rtl/dbq_pkg.sv
package dbq_pkg;
   localparam int REC_BYTES = 8;
   localparam int REC_BITS  = REC_BYTES * 8;
   localparam int REG_W     = 32;

   typedef enum logic [1:0] {
      RA_MODE = 2'd0,
      RA_STAT = 2'd1,
      RA_DEQ  = 2'd2,
      RA_ENQ  = 2'd3
   } reg_sel_e;

   localparam int MODE_EN  = 0;
   localparam int MODE_ADV = 1;
   localparam int ST_QUEUED = 0;
   localparam int ST_FULL   = 4;
   localparam int ST_ERR    = 7;
endpackage

// File: rtl/dbq_ptr.sv
module dbq_ptr #(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step,
   output logic [ADDR_W-1:0] ptr
);
   logic [OFS_W-1:0] ofs_inc;

   assign ofs_inc = ptr[OFS_W-1:0] + OFS_W'(dbq_pkg::REC_BYTES);

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr <= '0;
      else if (load)
         ptr <= load_val;
      else if (step)
         ptr <= {ptr[ADDR_W-1:OFS_W], ofs_inc};
   end
endmodule

// File: rtl/dbq_regs.sv
module dbq_regs (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_we,
   input  logic       mode_en_d,
   input  logic [2:0] w1c,
   input  logic       set_err,
   input  logic       set_full,
   input  logic       nonempty,
   output logic       mode_en,
   output logic       st_err,
   output logic       st_full,
   output logic       st_q
);
   // w1c[2] error, w1c[1] full, w1c[0] queued
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_en <= 1'b0;
         st_err  <= 1'b0;
         st_full <= 1'b0;
         st_q    <= 1'b0;
      end else begin
         if (mode_we)
            mode_en <= mode_en_d;
         st_err  <= (st_err  & ~w1c[2]) | set_err;
         st_full <= (st_full & ~w1c[1]) | set_full;
         st_q    <= (st_q | nonempty) & ~w1c[0];
      end
   end
endmodule

// File: rtl/dbell_rx_queue.sv
module dbell_rx_queue #(
   parameter int ADDR_W          = 32,
   parameter int ENTRIES         = 512,
   parameter int ID_W            = 16,
   parameter int INFO_W          = 16,
   parameter bit STALL_WHEN_FULL = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         ev_valid,
   output logic                         ev_ready,
   input  logic                         ev_err,
   input  logic [ID_W-1:0]              ev_tid,
   input  logic [ID_W-1:0]              ev_sid,
   input  logic [INFO_W-1:0]            ev_info,
   output logic                         mem_wr_en,
   output logic [ADDR_W-1:0]            mem_wr_addr,
   output logic [dbq_pkg::REC_BITS-1:0] mem_wr_data,
   input  logic                         reg_wr,
   input  logic [1:0]                   reg_addr,
   input  logic [dbq_pkg::REG_W-1:0]    reg_wdata,
   output logic [dbq_pkg::REG_W-1:0]    reg_rdata,
   output logic                         irq
);
   import dbq_pkg::*;

   localparam int IDX_W = $clog2(ENTRIES);
   localparam int OFS_W = IDX_W + $clog2(REC_BYTES);
   localparam int PAD_W = REC_BITS - 2 * ID_W - INFO_W;

   generate
      if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_depth
         $error("ENTRIES must be a power of two, at least 2");
      end
      if (ID_W != 16 || INFO_W != 16) begin : g_bad_fields
         $error("record layout needs 16-bit ID and info fields");
      end
      if (ADDR_W > REG_W || ADDR_W <= OFS_W) begin : g_bad_addr
         $error("ADDR_W must exceed the region offset and fit a register");
      end
   endgenerate

   logic [ADDR_W-1:0] enq_ptr, deq_ptr, enq_inc;
   logic [OFS_W-1:0]  enq_ofs_inc;
   logic mode_en, st_err, st_full, st_q;
   logic empty, full, accept, do_write, deq_step;
   logic wr_mode, wr_stat, wr_deq, wr_enq;

   assign wr_mode = reg_wr && (reg_addr == RA_MODE);
   assign wr_stat = reg_wr && (reg_addr == RA_STAT);
   assign wr_deq  = reg_wr && (reg_addr == RA_DEQ);
   assign wr_enq  = reg_wr && (reg_addr == RA_ENQ);

   assign enq_ofs_inc = enq_ptr[OFS_W-1:0] + OFS_W'(REC_BYTES);
   assign enq_inc     = {enq_ptr[ADDR_W-1:OFS_W], enq_ofs_inc};
   assign empty       = (enq_ptr == deq_ptr);
   assign full        = (enq_inc == deq_ptr);

   generate
      if (STALL_WHEN_FULL) begin : g_stall
         assign ev_ready = mode_en & ~full;
      end else begin : g_drop
         assign ev_ready = mode_en;
      end
   endgenerate

   assign accept   = ev_valid & ev_ready;
   assign do_write = accept & ~ev_err & ~full;
   assign deq_step = wr_mode & reg_wdata[MODE_ADV] & ~empty;

   dbq_ptr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_enq (
      .clk(clk), .rst_n(rst_n), .load(wr_enq),
      .load_val(reg_wdata[ADDR_W-1:0]), .step(do_write), .ptr(enq_ptr));

   dbq_ptr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_deq (
      .clk(clk), .rst_n(rst_n), .load(wr_deq),
      .load_val(reg_wdata[ADDR_W-1:0]), .step(deq_step), .ptr(deq_ptr));

   dbq_regs u_regs (
      .clk(clk), .rst_n(rst_n),
      .mode_we(wr_mode), .mode_en_d(reg_wdata[MODE_EN]),
      .w1c({wr_stat & reg_wdata[ST_ERR], wr_stat & reg_wdata[ST_FULL],
            wr_stat & reg_wdata[ST_QUEUED]}),
      .set_err(accept & ev_err),
      .set_full(ev_valid & mode_en & full),
      .nonempty(~empty),
      .mode_en(mode_en), .st_err(st_err), .st_full(st_full), .st_q(st_q));

   assign mem_wr_en   = do_write;
   assign mem_wr_addr = enq_ptr;
   assign mem_wr_data = {{PAD_W{1'b0}}, ev_tid, ev_sid, ev_info};
   assign irq         = st_q & mode_en;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_MODE: reg_rdata[MODE_EN] = mode_en;
         RA_STAT: begin
            reg_rdata[ST_ERR]    = st_err;
            reg_rdata[ST_FULL]   = st_full;
            reg_rdata[ST_QUEUED] = st_q;
         end
         RA_DEQ:  reg_rdata = REG_W'(deq_ptr);
         default: reg_rdata = REG_W'(enq_ptr);
      endcase
   end
endmodule

// File: rtl/dbq_chk.sv
module dbq_chk #(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ev_valid,
   input logic              ev_ready,
   input logic              ev_err,
   input logic              mem_wr_en,
   input logic [ADDR_W-1:0] mem_wr_addr,
   input logic              reg_wr,
   input logic [1:0]        reg_addr,
   input logic              adv_bit,
   input logic [ADDR_W-1:0] enq_ptr,
   input logic [ADDR_W-1:0] deq_ptr,
   input logic              st_q
);
   logic [ADDR_W-1:0] chk_enq_next;
   assign chk_enq_next = {enq_ptr[ADDR_W-1:OFS_W],
                          enq_ptr[OFS_W-1:0] + OFS_W'(dbq_pkg::REC_BYTES)};

   AST_WR_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> (ev_valid && ev_ready && !ev_err));  // R2
   AST_ENQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_en && !(reg_wr && reg_addr == dbq_pkg::RA_ENQ)) |=>
      (enq_ptr[OFS_W-1:0] == $past(mem_wr_addr[OFS_W-1:0]) + OFS_W'(dbq_pkg::REC_BYTES))
      && (enq_ptr[ADDR_W-1:OFS_W] == $past(mem_wr_addr[ADDR_W-1:OFS_W])));  // R3
   AST_EMPTY_ADV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == dbq_pkg::RA_MODE && adv_bit && enq_ptr == deq_ptr)
      |=> $stable(deq_ptr));  // R4
   AST_QUEUED_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q) |-> $past(enq_ptr != deq_ptr));  // R5
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_enq_next == deq_ptr) |-> !mem_wr_en);  // R6
   AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_err) |-> !mem_wr_en);  // R7
endmodule

bind dbell_rx_queue dbq_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_dbq_chk (
   .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
   .ev_err(ev_err), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
   .reg_wr(reg_wr), .reg_addr(reg_addr), .adv_bit(reg_wdata[1]),
   .enq_ptr(enq_ptr), .deq_ptr(deq_ptr), .st_q(st_q));

// File: tb/test_dbell_rx_queue.sv
`timescale 1ns/1ps
module test_dbell_rx_queue;
   logic clk = 1'b0, rst_n = 1'b0;
   logic ev_valid = 0, ev_err = 0, reg_wr = 0;
   logic [15:0] ev_tid = 0, ev_sid = 0, ev_info = 0;
   logic [1:0]  reg_addr = 0;
   logic [31:0] reg_wdata = 0;
   logic ev_ready, mem_wr_en, irq;
   logic [31:0] mem_wr_addr, reg_rdata;
   logic [63:0] mem_wr_data;

   dbell_rx_queue i_dbell_rx_queue (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
      .ev_err(ev_err), .ev_tid(ev_tid), .ev_sid(ev_sid), .ev_info(ev_info),
      .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq));

   always #2.5 clk = ~clk;

   int n_chk = 0, n_err = 0, acc = 0;
   bit done = 0;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   bit m_en, m_e, m_f, m_q;
   logic [31:0] m_enq, m_deq;

   function automatic logic [31:0] nxt(input logic [31:0] p);
      return {p[31:12], p[11:0] + 12'd8};
   endfunction

   wire e_empty = (m_enq == m_deq);
   wire e_full  = (nxt(m_enq) == m_deq);
   wire e_ready = m_en & ~e_full;
   wire e_acc   = ev_valid & e_ready;
   wire e_wr    = e_acc & ~ev_err;
   wire [31:0] e_clr = (reg_wr && reg_addr == 2'd1) ? reg_wdata : 32'h0;
   wire [31:0] e_rd = (reg_addr == 2'd0) ? {31'b0, m_en} :
                      (reg_addr == 2'd1) ? {24'b0, m_e, 2'b0, m_f, 3'b0, m_q} :
                      (reg_addr == 2'd2) ? m_deq : m_enq;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en <= 0; m_e <= 0; m_f <= 0; m_q <= 0; m_enq <= 0; m_deq <= 0;
      end else begin
         m_e <= (m_e & ~e_clr[7]) | (e_acc & ev_err);
         m_f <= (m_f & ~e_clr[4]) | (ev_valid & m_en & e_full);
         m_q <= (m_q | ~e_empty) & ~e_clr[0];
         if (reg_wr && reg_addr == 2'd0) m_en <= reg_wdata[0];
         if (reg_wr && reg_addr == 2'd3) m_enq <= reg_wdata;
         else if (e_wr) m_enq <= nxt(m_enq);
         if (reg_wr && reg_addr == 2'd2) m_deq <= reg_wdata;
         else if (reg_wr && reg_addr == 2'd0 && reg_wdata[1] && !e_empty)
            m_deq <= nxt(m_deq);
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R6 ev_ready", ev_ready, e_ready);
         chk("R2 mem_wr_en", mem_wr_en, e_wr);
         if (e_wr) begin
            chk("R3 mem_wr_addr", mem_wr_addr, m_enq);
            chk("R2 mem_wr_data", mem_wr_data, {16'h0, ev_tid, ev_sid, ev_info});
         end
         chk("R5 irq", irq, m_q & m_en);
         chk("R10 reg_rdata", reg_rdata, e_rd);
         if (mem_wr_en) acc++;
      end
   end

   task automatic drv(bit v, bit er, logic [15:0] t, logic [15:0] s, logic [15:0] inf,
                      bit w, logic [1:0] a, logic [31:0] d);
      @(posedge clk); #1;
      ev_valid = v; ev_err = er; ev_tid = t; ev_sid = s; ev_info = inf;
      reg_wr = w; reg_addr = a; reg_wdata = d;
   endtask
   task automatic idle();  drv(0, 0, 0, 0, 0, 0, 0, 0); endtask
   task automatic wreg(logic [1:0] a, logic [31:0] d); drv(0, 0, 0, 0, 0, 1, a, d); endtask
   task automatic ev(logic [15:0] t, logic [15:0] s, logic [15:0] inf, bit er);
      drv(1, er, t, s, inf, 0, 0, 0);
   endtask
   task automatic rd(logic [1:0] a, logic [31:0] exp, string tag);
      drv(0, 0, 0, 0, 0, 0, a, 0);
      @(negedge clk);
      chk(tag, reg_rdata, exp);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      rd(0, 0, "R1 mode after reset");
      chk("R1 ev_ready", ev_ready, 0);
      chk("R1 irq", irq, 0);
      rd(1, 0, "R1 status after reset");
      rd(2, 0, "R1 deq after reset");
      rd(3, 0, "R1 enq after reset");

      // set up near the 4 KB boundary
      wreg(3, 32'h0001_0FF0);
      wreg(2, 32'h0001_0FF0);
      wreg(1, 32'h91);
      wreg(0, 32'h3);
      rd(0, 1, "R9 mode readback, advance bit reads 0");
      rd(2, 32'h0001_0FF0, "R10 deq load");
      ev(16'h0A0B, 16'h0C0D, 16'h1234, 0);
      ev(16'h1111, 16'h2222, 16'h3333, 0);
      ev(16'hFEDC, 16'hBA98, 16'h7654, 0);
      idle();
      rd(3, 32'h0001_0008, "R3 enq wraps in region");
      rd(1, 32'h1, "R5 queued set");
      chk("R5 irq pending", irq, 1);

      wreg(0, 32'h3); wreg(0, 32'h3); wreg(0, 32'h3);
      rd(2, 32'h0001_0008, "R4 deq advanced and wrapped");
      wreg(1, 32'h1);
      rd(1, 0, "R5 queued stays clear when empty");
      chk("R5 irq low when empty", irq, 0);
      wreg(0, 32'h3);
      rd(2, 32'h0001_0008, "R4 advance on empty ignored");

      ev(16'h0001, 16'h0002, 16'h0003, 0);
      idle(); idle();
      wreg(1, 32'h1);
      rd(1, 0, "R5 queued cleared by ack");
      rd(1, 1, "R5 queued reasserted with record left");

      ev(16'h5555, 16'h6666, 16'h7777, 1);
      idle();
      rd(1, 32'h81, "R7 error status set");
      rd(3, 32'h0001_0010, "R7 enq unchanged by error event");
      wreg(1, 32'h91);
      rd(1, 0, "R8 write 0x91 clears status");

      // fill the queue
      wreg(3, 32'h0000_2000);
      wreg(2, 32'h0000_2000);
      wreg(1, 32'h91);
      acc = 0;
      for (int i = 0; i < 520; i++)
         ev(16'(i), ~16'(i), 16'(i) ^ 16'h5A5A, 0);
      idle();
      chk("R6 accepted count when filling", acc, 511);
      rd(1, 32'h11, "R6 full status set");
      rd(3, 32'h0000_2FF8, "R6 enq stops one slot short");
      wreg(0, 32'h3);
      ev(16'hAAAA, 16'hBBBB, 16'hCCCC, 0);
      idle();
      chk("R6 room after dequeue", acc, 512);

      wreg(0, 32'h0);
      ev(16'h1, 16'h2, 16'h3, 0);
      idle();
      chk("R9 disabled takes nothing", acc, 512);
      chk("R9 ev_ready low when disabled", ev_ready, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule